// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural integer registers of a 32-bit processor core. Sixteen registers are addressed through 4-bit indices, and index n always names register Rn. Index 13 is the stack pointer, index 14 is the link register and index 15 is the program counter. A 5-bit processor-mode input selects the physical storage that each index reaches. In the fast-interrupt mode, indices 8 to 14 reach a private set of seven registers, so its handlers can run with little context saving. The interrupt, supervisor, abort and undefined-instruction modes each own a private stack pointer and link register. User and system modes share the base set. The program counter is one physical register that every mode shares. In total there are 31 physical registers.

The block has one write port and two read ports. Each port carries its own index, and all three follow the same mode input. Read data is registered, so it appears one clock after the index is presented. A read of the index that is being written in the same cycle returns the value held before the write. The physical storage is copied once for each read port, and every copy is a simple dual-port memory with a registered output, so that it can map onto block RAM.

Top module: `banked_regfile`

## Requirements
- R1: In user mode (code 10000), a value written to index n (0 to 15) reads back from index n, and different indices hold independent values.
- R2: System mode (code 11111) and any mode code not listed in R3 or R4 reach exactly the user-mode registers for all 16 indices, for both reads and writes.
- R3: In fast-interrupt mode (code 10001), indices 8 to 14 reach seven private registers. Writes there leave the user-mode values of indices 8 to 14 untouched, and indices 0 to 7 reach the user-mode registers.
- R4: In the interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, indices 13 and 14 reach a pair of registers private to each mode. Indices 0 to 12 reach the user-mode registers.
- R5: Index 15 reaches one physical register from every mode, so a write to it in any mode is read back in every other mode.
- R6: Read data appears on the clock edge after the index and mode are presented. A read of an index written in that same cycle returns the old value, and the new value appears from the next cycle on.
- R7: A write lands in the bank that the mode input selects during the write cycle, and it is not visible through the same banked index in any other mode.
- R8: The two read ports operate independently and can present different indices in the same cycle.
- R9: Synchronous active-high reset drives both read outputs to zero and leaves every stored register value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| cpu_mode | input | 5 | Current processor mode code; selects the bank for all ports |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| rd_a_idx | input | 4 | Read port A index |
| rd_b_idx | input | 4 | Read port B index |
| rd_a_data | output | 32 | Read port A data, registered |
| rd_b_data | output | 32 | Read port B data, registered |

## Verification
The checks on the index mapping assume that the mode, index and write inputs are defined on every clock edge after reset. The write-then-read property assumes that read data depends only on the last write to a physical location. The bench changes every input only at the falling clock edge and never leaves one undriven. It keeps write enable low whenever no write is intended, so no stray write can mask a banking error. Unknown mode codes are used only for reads, after the user bank already holds known values.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_t;

  localparam int NUM_BANKS = 6;
  // banks that own only a stack pointer and link register
  localparam int NUM_SMALL_BANKS = 4;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

endpackage

// File: rtl/mbrf_mode_dec.sv
module mbrf_mode_dec
  import mbrf_pkg::*;
#(
  parameter int MODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  output bank_t             bank,
  output logic [NUM_BANKS-1:0] bank_oh
);

  always_comb begin
    unique case (mode)
      MODE_FIQ: bank = BK_FIQ;
      MODE_IRQ: bank = BK_IRQ;
      MODE_SVC: bank = BK_SVC;
      MODE_ABT: bank = BK_ABT;
      MODE_UND: bank = BK_UND;
      default:  bank = BK_USR;  // user, system and unknown codes
    endcase
  end

  always_comb begin
    bank_oh = '0;
    bank_oh[int'(bank)] = 1'b1;
  end

  // R2
  bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_oh) == 1);

  // R2
  sys_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SYS) |-> bank_oh[int'(BK_USR)]);

endmodule

// File: rtl/mbrf_map.sv
module mbrf_map
  import mbrf_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int FIQ_FIRST  = 8,
  parameter int SMALL_FIRST = 13,
  parameter int AW         = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  bank_t            bank,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    pa
);

  localparam int NUM_IDX    = 1 << IDX_W;
  localparam int PC_IDX     = NUM_IDX - 1;
  localparam int FIQ_N      = PC_IDX - FIQ_FIRST;
  localparam int SMALL_N    = PC_IDX - SMALL_FIRST;
  localparam int FIQ_BASE   = NUM_IDX;
  localparam int SMALL_BASE = FIQ_BASE + FIQ_N;
  localparam int NUM_PHYS   = SMALL_BASE + NUM_SMALL_BANKS * SMALL_N;

  always_comb begin
    pa = AW'(int'(idx));
    if (int'(idx) != PC_IDX) begin
      if (bank == BK_FIQ && int'(idx) >= FIQ_FIRST) begin
        pa = AW'(FIQ_BASE + int'(idx) - FIQ_FIRST);
      end else if (bank != BK_USR && bank != BK_FIQ && int'(idx) >= SMALL_FIRST) begin
        pa = AW'(SMALL_BASE + (int'(bank) - int'(BK_IRQ)) * SMALL_N
                 + int'(idx) - SMALL_FIRST);
      end
    end
  end

  // R5
  pc_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(idx) == PC_IDX) |-> (int'(pa) == PC_IDX));

  // R4
  low_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (bank != BK_FIQ && int'(idx) < SMALL_FIRST) |-> (int'(pa) == int'(idx)));

  // R3
  fiq_private_chk: assert property (@(posedge clk) disable iff (rst)
    (bank == BK_FIQ && int'(idx) >= FIQ_FIRST && int'(idx) < PC_IDX)
      |-> (int'(pa) >= FIQ_BASE && int'(pa) < SMALL_BASE));

  // R1
  pa_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(pa) < NUM_PHYS);

endmodule

// File: rtl/mbrf_ram.sv
module mbrf_ram #(
  parameter int DEPTH  = 31,
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rq
);

  logic [DATA_W-1:0] mem [DEPTH];

  // write port: no reset, storage keeps its contents
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // read-first registered output
  always_ff @(posedge clk) begin
    if (rst) rq <= '0;
    else     rq <= mem[ra];
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 4,
  parameter int MODE_W      = 5,
  parameter int FIQ_FIRST   = 8,
  parameter int SMALL_FIRST = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);

  localparam int NUM_IDX  = 1 << IDX_W;
  localparam int PC_IDX   = NUM_IDX - 1;
  localparam int NUM_PHYS = NUM_IDX + (PC_IDX - FIQ_FIRST)
                            + NUM_SMALL_BANKS * (PC_IDX - SMALL_FIRST);
  localparam int AW       = $clog2(NUM_PHYS);
  localparam int NRD      = 2;
  localparam int NPORT    = NRD + 1;

  bank_t                 bank;
  logic [NUM_BANKS-1:0]  bank_oh;
  logic [IDX_W-1:0]      idx_arr [NPORT];
  logic [AW-1:0]         pa_arr  [NPORT];
  logic [DATA_W-1:0]     rq      [NRD];

  mbrf_mode_dec #(.MODE_W(MODE_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .mode    (cpu_mode),
    .bank    (bank),
    .bank_oh (bank_oh)
  );

  assign idx_arr[0] = wr_idx;
  assign idx_arr[1] = rd_a_idx;
  assign idx_arr[2] = rd_b_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    mbrf_map #(
      .IDX_W       (IDX_W),
      .FIQ_FIRST   (FIQ_FIRST),
      .SMALL_FIRST (SMALL_FIRST),
      .AW          (AW)
    ) u_map (
      .clk  (clk),
      .rst  (rst),
      .bank (bank),
      .idx  (idx_arr[p]),
      .pa   (pa_arr[p])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_copy
    mbrf_ram #(
      .DEPTH  (NUM_PHYS),
      .DATA_W (DATA_W),
      .AW     (AW)
    ) u_ram (
      .clk (clk),
      .rst (rst),
      .we  (wr_en),
      .wa  (pa_arr[0]),
      .wd  (wr_data),
      .ra  (pa_arr[r+1]),
      .rq  (rq[r])
    );
  end

  assign rd_a_data = rq[0];
  assign rd_b_data = rq[1];

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

  // R6
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en ##1 (pa_arr[1] == $past(pa_arr[0])) |=> (rd_a_data == $past(wr_data, 2)));

  // R8
  wr_then_rd_b_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en ##1 (pa_arr[2] == $past(pa_arr[0])) |=> (rd_b_data == $past(wr_data, 2)));

endmodule

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cpu_mode = M_USR;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_a_idx = '0;
  logic [3:0]  rd_b_idx = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  banked_regfile dut (
    .clk (clk), .rst (rst), .cpu_mode (cpu_mode),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
    .rd_a_idx (rd_a_idx), .rd_b_idx (rd_b_idx),
    .rd_a_data (rd_a_data), .rd_b_data (rd_b_data)
  );

  function automatic logic [31:0] uval(int i);
    return 32'h1000_0000 | i;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_write(logic [4:0] m, int i, logic [31:0] d);
    cpu_mode = m; wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [4:0] m, int a, int b,
                         output logic [31:0] ra, output logic [31:0] rb);
    cpu_mode = m; rd_a_idx = 4'(a); rd_b_idx = 4'(b);
    @(negedge clk);
    ra = rd_a_data; rb = rd_b_data;
  endtask

  task automatic t_reset_out();
    // R9: outputs are zero while reset is held
    check("R9 reset a", rd_a_data, 32'h0);
    check("R9 reset b", rd_b_data, 32'h0);
  endtask

  task automatic t_user_basic();
    logic [31:0] a, b;
    for (int i = 0; i < 16; i++) do_write(M_USR, i, uval(i));
    for (int i = 0; i < 16; i++) begin
      do_read(M_USR, i, 15 - i, a, b);
      check("R1 user a", a, uval(i));
      check("R8 user b", b, uval(15 - i));
    end
  endtask

  task automatic t_system_alias();
    logic [31:0] a, b;
    for (int i = 0; i < 16; i++) begin
      do_read(M_SYS, i, i, a, b);
      check("R2 sys sees user", a, uval(i));
    end
    do_write(M_SYS, 3, 32'h3333_0003);
    do_read(M_USR, 3, 13, a, b);
    check("R2 sys write to user", a, 32'h3333_0003);
    check("R2 user sp", b, uval(13));
    do_read(5'b00000, 14, 9, a, b);
    check("R2 unknown code lr", a, uval(14));
    check("R2 unknown code r9", b, uval(9));
  endtask

  task automatic t_fiq();
    logic [31:0] a, b;
    for (int i = 8; i < 15; i++) do_write(M_FIQ, i, 32'hF100_0000 | i);
    for (int i = 8; i < 15; i++) begin
      do_read(M_FIQ, i, i, a, b);
      check("R3 fiq private", a, 32'hF100_0000 | i);
      do_read(M_USR, i, i, a, b);
      check("R3 user untouched", b, uval(i));
    end
    for (int i = 0; i < 8; i++) begin
      if (i == 3) continue;
      do_read(M_FIQ, i, i, a, b);
      check("R3 fiq low shared", a, uval(i));
    end
  endtask

  task automatic t_small_banks();
    logic [31:0] a, b;
    logic [4:0] ms [4] = '{M_IRQ, M_SVC, M_ABT, M_UND};
    for (int k = 0; k < 4; k++) begin
      do_write(ms[k], 13, 32'h5D00_0000 | k);
      do_write(ms[k], 14, 32'h5E00_0000 | k);
    end
    for (int k = 0; k < 4; k++) begin
      do_read(ms[k], 13, 14, a, b);
      check("R4 private sp", a, 32'h5D00_0000 | k);
      check("R4 private lr", b, 32'h5E00_0000 | k);
      do_read(ms[k], 12, 8, a, b);
      check("R4 r12 shared", a, uval(12));
      check("R4 r8 shared", b, uval(8));
    end
    do_read(M_USR, 13, 14, a, b);
    check("R4 user sp kept", a, uval(13));
    check("R4 user lr kept", b, uval(14));
    do_read(M_FIQ, 13, 14, a, b);
    check("R4 fiq sp kept", a, 32'hF100_000D);
    check("R4 fiq lr kept", b, 32'hF100_000E);
  endtask

  task automatic t_pc();
    logic [31:0] a, b;
    do_write(M_IRQ, 15, 32'hC0DE_0F00);
    do_read(M_FIQ, 15, 15, a, b);
    check("R5 pc in fiq", a, 32'hC0DE_0F00);
    do_read(M_USR, 15, 15, a, b);
    check("R5 pc in user", a, 32'hC0DE_0F00);
    do_read(M_UND, 15, 15, a, b);
    check("R5 pc in und", b, 32'hC0DE_0F00);
  endtask

  task automatic t_rdw();
    // R6: same-cycle read returns old value, next cycle the new one
    cpu_mode = M_USR; rd_a_idx = 4'd5; rd_b_idx = 4'd5;
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h5555_5555;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 old value", rd_a_data, uval(5));
    @(negedge clk);
    check("R6 new value", rd_b_data, 32'h5555_5555);
  endtask

  task automatic t_write_mode();
    logic [31:0] a, b;
    do_write(M_ABT, 14, 32'hAB0E_AB0E);
    do_read(M_ABT, 14, 14, a, b);
    check("R7 lands in abort", a, 32'hAB0E_AB0E);
    do_read(M_SVC, 14, 14, a, b);
    check("R7 not in svc", a, 32'h5E00_0001);
    do_read(M_UND, 14, 14, a, b);
    check("R7 not in und", b, 32'h5E00_0003);
  endtask

  task automatic t_mid_reset();
    logic [31:0] a, b;
    cpu_mode = M_USR; rd_a_idx = 4'd0; rd_b_idx = 4'd15;
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset a", rd_a_data, 32'h0);
    check("R9 mid reset b", rd_b_data, 32'h0);
    rst = 1'b0;
    do_read(M_USR, 0, 15, a, b);
    check("R9 storage kept", a, uval(0));
    check("R9 pc kept", b, 32'hC0DE_0F00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_out();
    rst = 1'b0;
    t_user_basic();
    t_system_alias();
    t_fiq();
    t_small_banks();
    t_pc();
    t_rdw();
    t_write_mode();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule